// File: doc/BRIEF.md
# Zoned External Bus Cycle Controller

This block turns internal read and write requests into cycles on an external memory and I/O bus. It splits the address space into zones: two fast memory zones, one slow memory zone and an I/O zone. Each zone has its own eight-bit configuration register. The register sets the wait states, the hold clocks after the strobe, the data width, whether reads may finish in a single strobe clock, and whether an idle clock is inserted when the bus moves into that zone from another one.

A request is presented with a valid flag and stays asserted until the block returns a one-clock ready pulse. When the request is accepted, the block decodes the target zone from the address and the I/O flag. It takes a copy of that zone's configuration, then runs the chip-select and strobe sequence for the zone. An idle clock before the cycle keeps the drivers of two zones from overlapping on the data lines.

Top module: `zbus_ctrl`

## Requirements
- R1: Memory requests with address below 0x4000 select zone 0, below 0x8000 zone 1, and otherwise zone 2. Requests flagged as I/O select zone 3. The selected zone drives the one-hot chip-select bit of the same index, and no chip select is active between cycles.
- R2: With fast read off, read and write strobes each last 2 + W clocks, where W is the zone's wait field (bits [2:0] of its configuration).
- R3: With fast read on (bit 6), a read strobe lasts 1 + W clocks. Writes to that zone keep 2 + W clocks.
- R4: After the strobe ends, chip select and address stay asserted with both strobes low for H more clocks, where H is the hold field (bits [4:3]).
- R5: One idle clock with no chip select comes before a cycle whose zone differs from the previous cycle's zone, provided the target zone's idle-before bit (bit 7) is set. No idle clock is inserted for the same zone, when that bit is clear, or before the first cycle after reset.
- R6: A cycle entering the I/O zone from another zone always gets the idle clock, whatever its idle-before bit holds.
- R7: Every configuration register resets to 0x9F: wait 7, hold 3, narrow, fast read off, idle-before on.
- R8: Ready is high for exactly one clock, the clock after the last strobe clock. Read data is captured at the end of the last strobe clock. A zone whose width bit (bit 5) is clear returns the low 8 bits, zero-extended.
- R9: A configuration write takes effect from the next accepted bus cycle and does not change a cycle already in progress.
- R10: During a write strobe the request data is driven on the bus with output enable high, and the write strobe is asserted.
- R11: Read and write strobes are never both high, and a strobe is only ever high while a chip select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_zone_i | input | 2 | Zone whose configuration is written |
| cfg_wdata_i | input | 8 | Configuration value |
| req_valid_i | input | 1 | Request pending |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | Request targets I/O space |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | One-clock completion pulse |
| req_rdata_o | output | DATA_W | Captured read data |
| bus_addr_o | output | ADDR_W | External address |
| bus_cs_o | output | 4 | One-hot zone chip selects |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_wdata_o | output | DATA_W | External write data |
| bus_wdata_oe_o | output | 1 | Write data output enable |
| bus_wide_o | output | 1 | Full-width cycle in progress |
| bus_rdata_i | input | DATA_W | External read data |

## Verification
The assertions check on every cycle that chip selects are at most one-hot and that the two strobes exclude each other and only occur under a chip select. They also check that the address holds steady through the whole chip-select window and that ready is a single pulse that follows the last strobe clock. Strobe lengths, hold lengths, idle-clock insertion on zone changes, the forced I/O idle clock, reset defaults, narrow zero-extension and the deferred effect of a configuration write all depend on the configuration history. Only the bench's transaction sequences can show them, by counting clocks at the pins against a memory model.

// File: rtl/zbus_pkg.sv
package zbus_pkg;
  localparam int NZONE   = 4;
  localparam int ZIDX_W  = 2;
  localparam int CFG_W   = 8;
  localparam int CNT_W   = 4;
  localparam logic [ZIDX_W-1:0] IO_ZONE = 2'd3;

  typedef struct packed {
    logic       ipre;   // idle clock before a cycle entering this zone
    logic       fre;    // single-clock read strobe base
    logic       wide;   // full-width data
    logic [1:0] hold;   // extra cs clocks after strobe
    logic [2:0] wst;    // wait states added to strobe
  } zcfg_t;

  localparam zcfg_t CFG_RST = '{ipre: 1'b1, fre: 1'b0, wide: 1'b0,
                                hold: 2'b11, wst: 3'b111};

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_STRB, ST_HOLD} seq_st_e;
endpackage

// File: rtl/zbus_decode.sv
module zbus_decode
  import zbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] Z1_BASE = 16'h4000,
  parameter logic [ADDR_W-1:0] Z2_BASE = 16'h8000
) (
  input  logic              io_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ZIDX_W-1:0] zone_o
);
  always_comb begin
    if (io_i)                 zone_o = IO_ZONE;
    else if (addr_i < Z1_BASE) zone_o = 2'd0;
    else if (addr_i < Z2_BASE) zone_o = 2'd1;
    else                      zone_o = 2'd2;
  end
endmodule

// File: rtl/zbus_cfg_regs.sv
module zbus_cfg_regs
  import zbus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ZIDX_W-1:0] wzone_i,
  input  zcfg_t             wdata_i,
  input  logic [ZIDX_W-1:0] rzone_i,
  output zcfg_t             rcfg_o
);
  zcfg_t cfg_q [NZONE];

  for (genvar z = 0; z < NZONE; z++) begin : g_zone
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   cfg_q[z] <= CFG_RST;
      else if (we_i && wzone_i == ZIDX_W'(z))        cfg_q[z] <= wdata_i;
    end
  end

  assign rcfg_o = cfg_q[rzone_i];
endmodule

// File: rtl/zbus_seq.sv
module zbus_seq
  import zbus_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ZIDX_W-1:0] req_zone_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  zcfg_t             zcfg_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] req_rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [NZONE-1:0]  bus_cs_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_wdata_oe_o,
  output logic              bus_wide_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  seq_st_e           st_q;
  zcfg_t             cur_cfg_q;
  logic [ZIDX_W-1:0] cur_zone_q, prev_zone_q;
  logic              prev_vld_q, wr_q, ready_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [CNT_W-1:0]  cnt_q;

  logic             accept, need_gap, cs_act;
  logic [CNT_W-1:0] strb_last;
  logic [DATA_W-1:0] rd_fmt;

  assign accept   = (st_q == ST_IDLE) && req_valid_i && !ready_q;
  assign need_gap = prev_vld_q && (req_zone_i != prev_zone_q)
                    && (zcfg_i.ipre || req_zone_i == IO_ZONE);
  // strobe clocks minus one: base 1 for fast reads, else 2
  assign strb_last = CNT_W'(zcfg_i.wst) +
                     ((!req_write_i && zcfg_i.fre) ? CNT_W'(0) : CNT_W'(1));
  assign rd_fmt = cur_cfg_q.wide ? bus_rdata_i
                                 : {{(DATA_W-NARROW_W){1'b0}}, bus_rdata_i[NARROW_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cur_cfg_q   <= CFG_RST;
      cur_zone_q  <= '0;
      prev_zone_q <= '0;
      prev_vld_q  <= 1'b0;
      wr_q        <= 1'b0;
      ready_q     <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      cnt_q       <= '0;
    end else begin
      ready_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          cur_cfg_q   <= zcfg_i;
          cur_zone_q  <= req_zone_i;
          prev_zone_q <= req_zone_i;
          prev_vld_q  <= 1'b1;
          wr_q        <= req_write_i;
          addr_q      <= req_addr_i;
          wdata_q     <= req_wdata_i;
          cnt_q       <= strb_last;
          st_q        <= need_gap ? ST_GAP : ST_STRB;
        end
        ST_GAP: st_q <= ST_STRB;
        ST_STRB: begin
          if (cnt_q == '0) begin
            if (!wr_q) rdata_q <= rd_fmt;
            ready_q <= 1'b1;
            if (cur_cfg_q.hold != '0) begin
              cnt_q <= CNT_W'(cur_cfg_q.hold) - CNT_W'(1);
              st_q  <= ST_HOLD;
            end else begin
              st_q  <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) st_q <= ST_IDLE;
          else             cnt_q <= cnt_q - CNT_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_act         = (st_q == ST_STRB) || (st_q == ST_HOLD);
  assign bus_cs_o       = cs_act ? (NZONE'(1) << cur_zone_q) : '0;
  assign bus_rd_o       = (st_q == ST_STRB) && !wr_q;
  assign bus_wr_o       = (st_q == ST_STRB) && wr_q;
  assign bus_wdata_oe_o = (st_q == ST_STRB) && wr_q;
  assign bus_wdata_o    = wdata_q;
  assign bus_addr_o     = addr_q;
  assign bus_wide_o     = cs_act && cur_cfg_q.wide;
  assign req_ready_o    = ready_q;
  assign req_rdata_o    = rdata_q;
endmodule

// File: rtl/zbus_ctrl.sv
module zbus_ctrl
  import zbus_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter logic [ADDR_W-1:0] Z1_BASE = 16'h4000,
  parameter logic [ADDR_W-1:0] Z2_BASE = 16'h8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_zone_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_io_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] req_rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [3:0]        bus_cs_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_wdata_oe_o,
  output logic              bus_wide_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  logic [ZIDX_W-1:0] req_zone;
  zcfg_t             zcfg;

  zbus_decode #(.ADDR_W(ADDR_W), .Z1_BASE(Z1_BASE), .Z2_BASE(Z2_BASE)) u_dec (
    .io_i   (req_io_i),
    .addr_i (req_addr_i),
    .zone_o (req_zone)
  );

  zbus_cfg_regs u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wzone_i (cfg_zone_i),
    .wdata_i (zcfg_t'(cfg_wdata_i)),
    .rzone_i (req_zone),
    .rcfg_o  (zcfg)
  );

  zbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_write_i    (req_write_i),
    .req_zone_i     (req_zone),
    .req_addr_i     (req_addr_i),
    .req_wdata_i    (req_wdata_i),
    .zcfg_i         (zcfg),
    .req_ready_o    (req_ready_o),
    .req_rdata_o    (req_rdata_o),
    .bus_addr_o     (bus_addr_o),
    .bus_cs_o       (bus_cs_o),
    .bus_rd_o       (bus_rd_o),
    .bus_wr_o       (bus_wr_o),
    .bus_wdata_o    (bus_wdata_o),
    .bus_wdata_oe_o (bus_wdata_oe_o),
    .bus_wide_o     (bus_wide_o),
    .bus_rdata_i    (bus_rdata_i)
  );
endmodule

// File: rtl/zbus_chk.sv
module zbus_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [3:0]        bus_cs_o,
  input logic              bus_rd_o,
  input logic              bus_wr_o
);
  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bus_cs_o)); // R1
  AST_STRB_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o)); // R11
  AST_STRB_UNDER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o || bus_wr_o) |-> (|bus_cs_o)); // R11
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|bus_cs_o) && $past(|bus_cs_o)) |-> $stable(bus_addr_o)); // R4
  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> !req_ready_o); // R8
  AST_READY_AFTER_STRB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> ($past(bus_rd_o || bus_wr_o) && !(bus_rd_o || bus_wr_o))); // R8
endmodule

bind zbus_ctrl zbus_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .bus_addr_o  (bus_addr_o),
  .bus_cs_o    (bus_cs_o),
  .bus_rd_o    (bus_rd_o),
  .bus_wr_o    (bus_wr_o)
);

// File: tb/sim_zbus_ctrl.sv
module sim_zbus_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  typedef struct packed {
    logic        wr;
    logic        io;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [1:0]  zone;
    logic        wide;
    logic [3:0]  pre;
    logic [3:0]  strb;
    logic [3:0]  hold;
  } vec_t;

  // zone cfg: z0 0xE0, z1 0x2A, z2 0x91, z3 0x20
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b0, 16'h0010, 16'h0000, 2'd0, 1'b1, 4'd0, 4'd1, 4'd0}, // R3 fast read
    '{1'b1, 1'b0, 16'h0010, 16'hBEEF, 2'd0, 1'b1, 4'd0, 4'd2, 4'd0}, // R3 write base 2
    '{1'b0, 1'b0, 16'h0010, 16'h0000, 2'd0, 1'b1, 4'd0, 4'd1, 4'd0}, // R10 readback
    '{1'b0, 1'b0, 16'h4000, 16'h0000, 2'd1, 1'b1, 4'd0, 4'd4, 4'd1}, // R5 ipre clear
    '{1'b0, 1'b0, 16'h8004, 16'h0000, 2'd2, 1'b0, 4'd1, 4'd3, 4'd2}, // R5 gap, R8 narrow
    '{1'b1, 1'b0, 16'h8004, 16'h1234, 2'd2, 1'b0, 4'd0, 4'd3, 4'd2}, // R2 write
    '{1'b0, 1'b0, 16'h8004, 16'h0000, 2'd2, 1'b0, 4'd0, 4'd3, 4'd2}, // R8 narrow
    '{1'b0, 1'b1, 16'h0008, 16'h0000, 2'd3, 1'b1, 4'd1, 4'd2, 4'd0}, // R6 forced gap
    '{1'b0, 1'b1, 16'h0008, 16'h0000, 2'd3, 1'b1, 4'd0, 4'd2, 4'd0}, // R5 same zone
    '{1'b0, 1'b0, 16'h7FFE, 16'h0000, 2'd1, 1'b1, 4'd0, 4'd4, 4'd1}, // R1 upper edge z1
    '{1'b0, 1'b0, 16'h3FFF, 16'h0000, 2'd0, 1'b1, 4'd1, 4'd1, 4'd0}, // R1 upper edge z0
    '{1'b1, 1'b1, 16'h0002, 16'hA5A5, 2'd3, 1'b1, 4'd1, 4'd2, 4'd0}  // R6 io write
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_zone_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0, req_io_i = 1'b0;
  logic [15:0] req_addr_i = '0, req_wdata_i = '0;
  logic        req_ready_o, bus_rd_o, bus_wr_o, bus_wdata_oe_o, bus_wide_o;
  logic [15:0] req_rdata_o, bus_addr_o, bus_wdata_o, bus_rdata_i;
  logic [3:0]  bus_cs_o;

  int checks = 0;
  int errors = 0;

  logic [15:0] mem    [512];
  logic [15:0] shadow [512];
  logic [8:0]  midx;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  zbus_ctrl u0 (.*);

  assign midx        = {bus_cs_o[3], bus_addr_o[7:0]};
  assign bus_rdata_i = mem[midx];
  always @(posedge clk_i) if (bus_wr_o && bus_wdata_oe_o) mem[midx] <= bus_wdata_o;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] z, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_zone_i = z; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic do_txn(input vec_t v, input logic mid_we,
                        input logic [1:0] mid_z, input logic [7:0] mid_d);
    int pre = 0, strb = 0, hold = 0, rdy = 0, guard = 0;
    logic seen_cs = 1'b0, cs_bad = 1'b0, wide_bad = 1'b0, oe_bad = 1'b0;
    logic [15:0] rdata = '0, expd;
    logic [8:0] sidx = {v.io, v.addr[7:0]};
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = v.wr; req_io_i = v.io;
    req_addr_i = v.addr; req_wdata_i = v.wdata;
    forever begin
      @(negedge clk_i);
      guard++;
      if (cfg_we_i) cfg_we_i = 1'b0;
      if (req_ready_o) begin
        rdy++; rdata = req_rdata_o; req_valid_i = 1'b0;
      end
      if (|bus_cs_o) begin
        seen_cs = 1'b1;
        if (bus_cs_o != (4'b1 << v.zone)) cs_bad = 1'b1;
        if (bus_wide_o != v.wide) wide_bad = 1'b1;
        if (bus_rd_o || bus_wr_o) begin
          strb++;
          if (v.wr && !(bus_wr_o && bus_wdata_oe_o && bus_wdata_o == v.wdata)) oe_bad = 1'b1;
          if (mid_we && strb == 1) begin
            cfg_we_i = 1'b1; cfg_zone_i = mid_z; cfg_wdata_i = mid_d;
          end
        end else hold++;
      end else if (!seen_cs) pre++;
      if ((seen_cs && !(|bus_cs_o) && rdy > 0) || guard > 60) break;
    end
    req_valid_i = 1'b0;
    chk(pre == int'(v.pre), "R5 idle clocks before cycle", pre, v.pre);
    chk(strb == int'(v.strb), "R2 strobe clocks", strb, v.strb);
    chk(hold == int'(v.hold), "R4 hold clocks", hold, v.hold);
    chk(rdy == 1, "R8 ready pulse count", rdy, 1);
    chk(!cs_bad, "R1 chip select index", v.zone, v.zone);
    chk(!wide_bad, "R8 width indication", 0, 0);
    if (v.wr) begin
      chk(!oe_bad, "R10 write data on bus", 0, 0);
      shadow[sidx] = v.wdata;
    end else begin
      expd = v.wide ? shadow[sidx] : {8'h00, shadow[sidx][7:0]};
      chk(rdata == expd, "R8 read data", rdata, expd);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i]    = 16'(i * 16'h0137) ^ 16'h5A00;
      shadow[i] = 16'(i * 16'h0137) ^ 16'h5A00;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b0, "R8 reset ready", req_ready_o, 0);
    chk(bus_cs_o == 4'b0, "R1 reset chip select", bus_cs_o, 0);
    chk(!bus_rd_o && !bus_wr_o, "R11 reset strobes", {bus_rd_o, bus_wr_o}, 0);

    // R7 defaults: wait 7, hold 3, narrow, no fast read, first cycle no gap
    do_txn('{1'b0, 1'b0, 16'h0020, 16'h0, 2'd0, 1'b0, 4'd0, 4'd9, 4'd3}, 1'b0, 2'd0, 8'h0);

    cfg_write(2'd0, 8'hE0);
    cfg_write(2'd1, 8'h2A);
    cfg_write(2'd2, 8'h91);
    cfg_write(2'd3, 8'h20);

    for (int k = 0; k < NVEC; k++) do_txn(VEC[k], 1'b0, 2'd0, 8'h0);

    // R9: z1 reprogrammed to wait 0 during a cycle; current cycle keeps wait 2
    do_txn('{1'b0, 1'b0, 16'h4002, 16'h0, 2'd1, 1'b1, 4'd0, 4'd4, 4'd1}, 1'b1, 2'd1, 8'h28);
    do_txn('{1'b0, 1'b0, 16'h4002, 16'h0, 2'd1, 1'b1, 4'd0, 4'd2, 4'd1}, 1'b0, 2'd0, 8'h0);

    // R3: fast-read zone write then idle-before on return to z0
    do_txn('{1'b1, 1'b0, 16'h0030, 16'h0F0F, 2'd0, 1'b1, 4'd1, 4'd2, 4'd0}, 1'b0, 2'd0, 8'h0);

    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule